// File: doc/BRIEF.md
# Transactional Cache Set Tracker

This block models the tag side of a 4-way set-associative first-level cache with 64-byte lines and 32 KB of capacity. It adds one speculative read bit and one speculative write bit to every line, so it can track the read set and the write set of a hardware memory transaction. The cache holds no data. The block handles tag lookup, line fill, victim selection, and the detection of events that must abort the transaction. The tracking unit is the whole line, so two objects that share a line also share conflicts.

Each cycle the block accepts at most one local access, with an address and a write flag. It also accepts one external probe from another agent, with an address and a write flag. Begin and commit pulses mark the edges of a transaction. One cycle after an access, the block reports:
- whether the access hit,
- which way was used or filled,
- whether a valid line was displaced.

An abort appears as a one-cycle pulse with a cause code. After an abort, local accesses have no effect until the next begin.

Top module: `txc_tracker`

## Requirements
- R1: After reset every line is invalid, no transaction is active and all outputs are 0. The first access to any set therefore misses and fills way 0.
- R2: The set index is address bits [12:6] and the tag is bits [31:13]. Two addresses that differ only in bits [5:0] hit the same line.
- R3: A miss displaces a valid line (respEvict=1) only when all 4 ways of its set are valid, even if other sets still have free ways. An evicted line no longer hits.
- R4: Each way has a use bit. The use bit is set when the way is hit or filled, and when all 4 use bits would become set, only the just-used bit remains set. The victim is chosen in this order:
  - the lowest-numbered invalid way;
  - otherwise the lowest-numbered non-speculative way whose use bit is clear;
  - otherwise the lowest-numbered non-speculative way;
  - otherwise the lowest-numbered way whose use bit is clear.
- R5: Inside a transaction, a miss whose victim is speculative raises an abort with cause 01. That response shows a miss, respEvict=1 and the victim way, and the missing line is not installed.
- R6: Inside a transaction, an external write to a line in the read set or the write set aborts with cause 10. An external read aborts only if the line is in the write set. A local access in the same cycle as a conflicting probe is dropped.
- R7: Conflicts are detected per line. A probe to any byte of a tracked line conflicts, even a byte that the transaction never touched.
- R8: Commit clears all speculative bits and keeps lines valid. Begin sets txActive from the next cycle, and commit clears it. Begin has no effect while a transaction is active.
- R9: An abort invalidates every line whose write bit is set, keeps lines that were only read, and clears all speculative bits.
- R10: After an abort, local accesses produce no response and change no state until the next begin.
- R11: Local accesses outside a transaction update tags and use bits but never set speculative bits, so a later probe cannot conflict with them.
- R12: abortPulse lasts exactly one cycle and drops txActive. abortCause is 00 whenever abortPulse is 0.
- R13: The response signals are registered and appear in the cycle after the access is sampled. While no accepted access is in flight, respHit, respWay and respEvict are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txBegin | input | 1 | Start-transaction pulse |
| txCommit | input | 1 | Commit pulse |
| accValid | input | 1 | Local access present |
| accAddr | input | 32 | Local byte address |
| accWrite | input | 1 | Local access is a write |
| snpValid | input | 1 | External probe present |
| snpAddr | input | 32 | Probe byte address |
| snpWrite | input | 1 | Probe is a write |
| respValid | output | 1 | Response for an accepted access |
| respHit | output | 1 | Access hit |
| respWay | output | 2 | Way hit or chosen for fill |
| respEvict | output | 1 | A valid line was displaced |
| abortPulse | output | 1 | Transaction abort pulse |
| abortCause | output | 2 | 01 capacity, 10 conflict |
| txActive | output | 1 | Transaction in progress |

## Verification
The assertions check the following on every cycle:
- abort pulses last one cycle and always carry a valid cause;
- a capacity abort always comes with a missing, evicting response;
- eviction never accompanies a hit;
- no response follows an abort.

Only the bench scenarios can show the behaviour that depends on stored history. This covers which way the victim order picks, whether a line is invalidated or kept after an abort, and whether probes conflict at line granularity and only against the right set. The bench checks these by comparing every cycle against a model built from the requirements. It runs directed cases and address streams confined to a few sets, which force evictions.

// File: rtl/txc_pkg.sv
package txc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_ABORTED = 2'd2
  } txState_t;

  typedef struct packed {
    logic touch;
    logic install;
    logic setRd;
    logic setWr;
    logic clearCommit;
    logic clearAbort;
  } dpCtrl_t;

  localparam logic [1:0] CAUSE_NONE     = 2'b00;
  localparam logic [1:0] CAUSE_CAPACITY = 2'b01;
  localparam logic [1:0] CAUSE_CONFLICT = 2'b10;
endpackage

// File: rtl/txc_datapath.sv
module txc_datapath
  import txc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 7,
  parameter int WAYS     = 4,
  localparam int SETS    = 1 << INDEX_W,
  localparam int TAG_W   = ADDR_W - INDEX_W - OFFSET_W,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [ADDR_W-1:0] snpAddr,
  input  dpCtrl_t           ctrl,
  output logic              accHit,
  output logic [WAY_W-1:0]  accWay,
  output logic              vicValid,
  output logic              vicSpec,
  output logic              snpInRd,
  output logic              snpInWr
);
  logic [SETS-1:0][WAYS-1:0] validQ, rdQ, wrQ, usedQ;
  logic [TAG_W-1:0] tagQ [SETS][WAYS];

  logic [INDEX_W-1:0] accSet, snpSet;
  logic [TAG_W-1:0]   accTag, snpTag;
  logic [WAYS-1:0]    hitVec, snpVec, specVec, usedTouched;
  logic [WAY_W-1:0]   hitWay, vicWay;
  logic               unusedOffsetBits;

  assign accSet = accAddr[OFFSET_W +: INDEX_W];
  assign snpSet = snpAddr[OFFSET_W +: INDEX_W];
  assign accTag = accAddr[ADDR_W-1 -: TAG_W];
  assign snpTag = snpAddr[ADDR_W-1 -: TAG_W];
  assign unusedOffsetBits = ^{accAddr[OFFSET_W-1:0], snpAddr[OFFSET_W-1:0]};

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_match
      assign hitVec[gw]  = validQ[accSet][gw] && (tagQ[accSet][gw] == accTag);
      assign snpVec[gw]  = validQ[snpSet][gw] && (tagQ[snpSet][gw] == snpTag);
      assign specVec[gw] = rdQ[accSet][gw] | wrQ[accSet][gw];
    end
  endgenerate

  function automatic logic [WAY_W-1:0] pickLow(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] idx;
    idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) idx = WAY_W'(i);
    end
    return idx;
  endfunction

  always_comb begin
    logic [WAYS-1:0] inv, nonSpec, used;
    inv     = ~validQ[accSet];
    nonSpec = ~specVec;
    used    = usedQ[accSet];
    if (inv != '0)                       vicWay = pickLow(inv);
    else if ((nonSpec & ~used) != '0)    vicWay = pickLow(nonSpec & ~used);
    else if (nonSpec != '0)              vicWay = pickLow(nonSpec);
    else                                 vicWay = pickLow(~used);
    hitWay   = pickLow(hitVec);
    accHit   = |hitVec;
    accWay   = accHit ? hitWay : vicWay;
    vicValid = validQ[accSet][vicWay];
    vicSpec  = specVec[vicWay];
    snpInRd  = |(snpVec & rdQ[snpSet]);
    snpInWr  = |(snpVec & wrQ[snpSet]);
  end

  always_comb begin
    logic [WAYS-1:0] oneHot;
    oneHot = '0;
    oneHot[accWay] = 1'b1;
    usedTouched = usedQ[accSet] | oneHot;
    if (&usedTouched) usedTouched = oneHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      rdQ    <= '0;
      wrQ    <= '0;
      usedQ  <= '0;
    end else begin
      if (ctrl.touch)   usedQ[accSet] <= usedTouched;
      if (ctrl.install) begin
        validQ[accSet][accWay] <= 1'b1;
        rdQ[accSet][accWay]    <= 1'b0;
        wrQ[accSet][accWay]    <= 1'b0;
      end
      if (ctrl.setRd) rdQ[accSet][accWay] <= 1'b1;
      if (ctrl.setWr) wrQ[accSet][accWay] <= 1'b1;
      if (ctrl.clearCommit) begin
        rdQ <= '0;
        wrQ <= '0;
      end
      if (ctrl.clearAbort) begin
        validQ <= validQ & ~wrQ;
        rdQ    <= '0;
        wrQ    <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ctrl.install) tagQ[accSet][accWay] <= accTag;
  end
endmodule

// File: rtl/txc_control.sv
module txc_control
  import txc_pkg::*;
#(
  parameter int WAYS   = 4,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txBegin,
  input  logic             txCommit,
  input  logic             accValid,
  input  logic             accWrite,
  input  logic             snpValid,
  input  logic             snpWrite,
  input  logic             accHit,
  input  logic [WAY_W-1:0] accWay,
  input  logic             vicValid,
  input  logic             vicSpec,
  input  logic             snpInRd,
  input  logic             snpInWr,
  output dpCtrl_t          ctrl,
  output logic             respValid,
  output logic             respHit,
  output logic [WAY_W-1:0] respWay,
  output logic             respEvict,
  output logic             abortPulse,
  output logic [1:0]       abortCause,
  output logic             txActive
);
  txState_t stateQ, stateD;
  logic active, snpConflict, accOk, capAbort, abortNow;

  always_comb begin
    active      = (stateQ == ST_ACTIVE);
    snpConflict = active && snpValid && (snpWrite ? (snpInRd || snpInWr) : snpInWr);
    accOk       = accValid && (stateQ != ST_ABORTED) && !snpConflict;
    capAbort    = accOk && active && !accHit && vicValid && vicSpec;
    abortNow    = snpConflict || capAbort;

    ctrl.touch       = accOk && !capAbort;
    ctrl.install     = ctrl.touch && !accHit;
    ctrl.setRd       = ctrl.touch && active && !accWrite;
    ctrl.setWr       = ctrl.touch && active && accWrite;
    ctrl.clearCommit = active && txCommit && !abortNow;
    ctrl.clearAbort  = abortNow;

    stateD = stateQ;
    if (abortNow)                stateD = ST_ABORTED;
    else if (active && txCommit) stateD = ST_IDLE;
    else if (!active && txBegin) stateD = ST_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      respValid  <= 1'b0;
      respHit    <= 1'b0;
      respWay    <= '0;
      respEvict  <= 1'b0;
      abortPulse <= 1'b0;
      abortCause <= CAUSE_NONE;
      txActive   <= 1'b0;
    end else begin
      stateQ     <= stateD;
      respValid  <= accOk;
      respHit    <= accOk && accHit;
      respWay    <= accOk ? accWay : '0;
      respEvict  <= accOk && !accHit && vicValid;
      abortPulse <= abortNow;
      abortCause <= snpConflict ? CAUSE_CONFLICT : (capAbort ? CAUSE_CAPACITY : CAUSE_NONE);
      txActive   <= (stateD == ST_ACTIVE);
    end
  end
endmodule

// File: rtl/txc_tracker.sv
module txc_tracker
  import txc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int INDEX_W  = 7,
  parameter int WAYS     = 4,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txBegin,
  input  logic              txCommit,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              snpWrite,
  output logic              respValid,
  output logic              respHit,
  output logic [WAY_W-1:0]  respWay,
  output logic              respEvict,
  output logic              abortPulse,
  output logic [1:0]        abortCause,
  output logic              txActive
);
  dpCtrl_t          ctrl;
  logic             accHit, vicValid, vicSpec, snpInRd, snpInWr;
  logic [WAY_W-1:0] accWay;

  txc_datapath #(
    .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .INDEX_W(INDEX_W), .WAYS(WAYS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .snpAddr(snpAddr), .ctrl(ctrl),
    .accHit(accHit), .accWay(accWay), .vicValid(vicValid), .vicSpec(vicSpec),
    .snpInRd(snpInRd), .snpInWr(snpInWr)
  );

  txc_control #(.WAYS(WAYS)) u_ctl (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txCommit(txCommit),
    .accValid(accValid), .accWrite(accWrite), .snpValid(snpValid), .snpWrite(snpWrite),
    .accHit(accHit), .accWay(accWay), .vicValid(vicValid), .vicSpec(vicSpec),
    .snpInRd(snpInRd), .snpInWr(snpInWr), .ctrl(ctrl),
    .respValid(respValid), .respHit(respHit), .respWay(respWay), .respEvict(respEvict),
    .abortPulse(abortPulse), .abortCause(abortCause), .txActive(txActive)
  );
endmodule

// File: rtl/txc_checker.sv
module txc_checker #(
  parameter int WAY_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             respValid,
  input logic             respHit,
  input logic [WAY_W-1:0] respWay,
  input logic             respEvict,
  input logic             abortPulse,
  input logic [1:0]       abortCause,
  input logic             txActive
);
  assert_pulse_single_R12: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !abortPulse);
  assert_cause_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> (abortCause == 2'b01 || abortCause == 2'b10));
  assert_cause_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !abortPulse |-> (abortCause == 2'b00));
  assert_abort_drops_active_R12: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> !txActive);
  assert_capacity_shape_R5: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse && abortCause == 2'b01) |-> (respValid && !respHit && respEvict));
  assert_evict_on_miss_R3: assert property (@(posedge clk) disable iff (!rstN)
    respEvict |-> (respValid && !respHit));
  assert_ignored_after_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |=> !respValid);
  assert_quiet_outputs_R13: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> (!respHit && respWay == '0 && !respEvict));
endmodule

bind txc_tracker txc_checker #(.WAY_W(WAY_W)) u_chk (
  .clk(clk), .rstN(rstN), .respValid(respValid), .respHit(respHit),
  .respWay(respWay), .respEvict(respEvict), .abortPulse(abortPulse),
  .abortCause(abortCause), .txActive(txActive)
);

// File: tb/tb_txc_tracker.sv
module tb_txc_tracker;
  logic clk = 1'b0, rstN = 1'b0;
  logic txBegin = 0, txCommit = 0, accValid = 0, accWrite = 0, snpValid = 0, snpWrite = 0;
  logic [31:0] accAddr = '0, snpAddr = '0;
  logic respValid, respHit, respEvict, abortPulse, txActive;
  logic [1:0] respWay, abortCause;

  int checks = 0, fails = 0;
  bit finished = 0;

  bit        mValid [128][4];
  bit [18:0] mTag   [128][4];
  bit        mRd    [128][4];
  bit        mWr    [128][4];
  bit        mUsed  [128][4];
  int        mState;

  always #5 clk = ~clk;

  txc_tracker dut (
    .clk(clk), .rstN(rstN), .txBegin(txBegin), .txCommit(txCommit),
    .accValid(accValid), .accAddr(accAddr), .accWrite(accWrite),
    .snpValid(snpValid), .snpAddr(snpAddr), .snpWrite(snpWrite),
    .respValid(respValid), .respHit(respHit), .respWay(respWay), .respEvict(respEvict),
    .abortPulse(abortPulse), .abortCause(abortCause), .txActive(txActive)
  );

  function automatic logic [31:0] mk(int t, int s, int o);
    return {t[18:0], s[6:0], o[5:0]};
  endfunction

  task automatic check(bit ok, string lbl, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%b exp=%b", lbl, act, exp);
    end
  endtask

  task automatic modelStep(bit beg, bit com, bit av, logic [31:0] aa, bit aw,
                           bit sv, logic [31:0] sa, bit sw, string tag,
                           output logic [8:0] exp, output string lbl);
    int as, ss, hw, vw;
    bit [18:0] at, st;
    bit hit, sRd, sWr, act, conf, ok, cap, abt, evict, allSet;
    bit [1:0] cause;
    as = int'(aa[12:6]); at = aa[31:13];
    ss = int'(sa[12:6]); st = sa[31:13];
    hit = 0; hw = 0; sRd = 0; sWr = 0;
    for (int w = 3; w >= 0; w--) begin
      if (mValid[as][w] && mTag[as][w] == at) begin hit = 1; hw = w; end
      if (mValid[ss][w] && mTag[ss][w] == st) begin sRd |= mRd[ss][w]; sWr |= mWr[ss][w]; end
    end
    vw = -1;
    for (int w = 3; w >= 0; w--) if (!mValid[as][w]) vw = w;
    if (vw < 0) for (int w = 3; w >= 0; w--) if (!(mRd[as][w] | mWr[as][w]) && !mUsed[as][w]) vw = w;
    if (vw < 0) for (int w = 3; w >= 0; w--) if (!(mRd[as][w] | mWr[as][w])) vw = w;
    if (vw < 0) for (int w = 3; w >= 0; w--) if (!mUsed[as][w]) vw = w;
    if (vw < 0) vw = 0;
    act   = (mState == 1);
    conf  = act && sv && (sw ? (sRd | sWr) : sWr);
    ok    = av && mState != 2 && !conf;
    cap   = ok && act && !hit && mValid[as][vw] && (mRd[as][vw] | mWr[as][vw]);
    evict = ok && !hit && mValid[as][vw];
    if (hit) vw = hw;
    if (ok && !cap) begin
      mUsed[as][vw] = 1;
      allSet = 1;
      for (int w = 0; w < 4; w++) allSet &= mUsed[as][w];
      if (allSet) for (int w = 0; w < 4; w++) mUsed[as][w] = (w == vw);
      if (!hit) begin mValid[as][vw] = 1; mTag[as][vw] = at; mRd[as][vw] = 0; mWr[as][vw] = 0; end
      if (act) begin if (aw) mWr[as][vw] = 1; else mRd[as][vw] = 1; end
    end
    abt = conf | cap;
    cause = conf ? 2'b10 : (cap ? 2'b01 : 2'b00);
    if (abt) begin
      for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin
        if (mWr[s][w]) mValid[s][w] = 0;
        mRd[s][w] = 0; mWr[s][w] = 0;
      end
      mState = 2;
    end else if (act && com) begin
      for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin mRd[s][w] = 0; mWr[s][w] = 0; end
      mState = 0;
    end else if (!act && beg) mState = 1;
    exp = {ok, ok && hit, ok ? 2'(vw) : 2'b00, evict, abt, cause, mState == 1};
    if (tag != "")        lbl = tag;
    else if (conf)        lbl = "R6";
    else if (cap)         lbl = "R5";
    else if (evict)       lbl = "R4";
    else if (ok)          lbl = "R2";
    else if (av)          lbl = "R10";
    else if (beg || com)  lbl = "R8";
    else                  lbl = "R12";
  endtask

  task automatic step(bit beg, bit com, bit av, logic [31:0] aa, bit aw,
                      bit sv, logic [31:0] sa, bit sw, string tag);
    logic [8:0] exp, act;
    string lbl;
    @(negedge clk);
    txBegin = beg; txCommit = com; accValid = av; accAddr = aa; accWrite = aw;
    snpValid = sv; snpAddr = sa; snpWrite = sw;
    modelStep(beg, com, av, aa, aw, sv, sa, sw, tag, exp, lbl);
    @(posedge clk); #1;
    act = {respValid, respHit, respWay, respEvict, abortPulse, abortCause, txActive};
    check(act === exp, lbl, act, exp);
  endtask

  task automatic acc(logic [31:0] a, bit w, string tag); step(0, 0, 1, a, w, 0, '0, 0, tag); endtask
  task automatic snp(logic [31:0] a, bit w, string tag); step(0, 0, 0, '0, 0, 1, a, w, tag); endtask
  task automatic beginTx(string tag);  step(1, 0, 0, '0, 0, 0, '0, 0, tag); endtask
  task automatic commitTx(string tag); step(0, 1, 0, '0, 0, 0, '0, 0, tag); endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    finishRun();
  end

  initial begin
    int seed;
    seed = $urandom(1234);
    mState = 0;
    for (int s = 0; s < 128; s++) for (int w = 0; w < 4; w++) begin
      mValid[s][w] = 0; mTag[s][w] = 0; mRd[s][w] = 0; mWr[s][w] = 0; mUsed[s][w] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    check({respValid, respHit, respWay, respEvict, abortPulse, abortCause, txActive} == 9'b0,
          "R1 reset outputs", {respValid, respHit, respWay, respEvict, abortPulse, abortCause, txActive}, 9'b0);

    acc(mk(1, 5, 0), 0, "R1 first miss way0 R13");
    acc(mk(1, 5, 63), 0, "R2 same line other offset hits");
    acc(mk(1, 6, 0), 0, "R2 other set misses");
    acc(mk(2, 5, 0), 0, "R3 fill way1");
    acc(mk(3, 5, 0), 0, "R3 fill way2");
    acc(mk(4, 5, 0), 1, "R3 fill way3 no evict");
    acc(mk(5, 5, 0), 0, "R3 full set evicts R4");
    acc(mk(1, 5, 0), 0, "R3 evicted line misses");

    beginTx("R8 begin");
    for (int t = 1; t <= 4; t++) acc(mk(t, 10, 0), 0, "R4 tx read fill");
    acc(mk(9, 10, 0), 0, "R5 capacity abort");
    acc(mk(9, 10, 0), 0, "R10 ignored after abort");
    beginTx("R8 begin again");
    acc(mk(1, 10, 8), 0, "R9 read line kept");
    commitTx("R8 commit");

    beginTx("R8 begin");
    acc(mk(7, 20, 0), 1, "R6 tx write");
    snp(mk(7, 20, 32), 0, "R7 probe other byte aborts");
    acc(mk(7, 20, 0), 0, "R10 ignored");
    beginTx("R8 begin");
    acc(mk(7, 20, 0), 0, "R9 written line invalidated");
    commitTx("R8 commit");

    beginTx("R8 begin");
    acc(mk(8, 21, 0), 0, "R6 tx read");
    snp(mk(8, 21, 0), 0, "R6 probe read of read set no abort");
    snp(mk(8, 21, 8), 1, "R6 probe write aborts");

    beginTx("R8 begin");
    acc(mk(3, 22, 0), 1, "R8 tx write");
    step(1, 0, 0, '0, 0, 0, '0, 0, "R8 begin while active ignored");
    commitTx("R8 commit");
    beginTx("R8 begin");
    snp(mk(3, 22, 0), 1, "R8 cleared bits no conflict");
    acc(mk(3, 22, 0), 0, "R8 line still valid");
    commitTx("R8 commit");

    acc(mk(4, 23, 0), 1, "R11 non-tx write");
    beginTx("R8 begin");
    snp(mk(4, 23, 0), 1, "R11 no spec bits outside tx");
    commitTx("R8 commit");

    for (int t = 1; t <= 4; t++) acc(mk(t, 30, 0), 0, "R4 non-tx fill");
    beginTx("R8 begin");
    acc(mk(1, 30, 0), 0, "R4 spec hit");
    acc(mk(2, 30, 0), 0, "R4 spec hit");
    acc(mk(6, 30, 0), 0, "R4 non-spec victim no abort");
    commitTx("R8 commit");
    step(0, 0, 0, '0, 0, 0, '0, 0, "R13 idle quiet");

    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [31:0] a;
      op = int'($urandom % 10);
      a = mk(int'($urandom % 6), int'($urandom % 3), int'($urandom % 64));
      case (op)
        0: beginTx("");
        1: commitTx("");
        2, 3: snp(a, bit'($urandom % 2), "");
        default: acc(a, bit'($urandom % 2), "");
      endcase
    end
    finishRun();
  end
endmodule